// File: doc/BRIEF.md
# Vector Length Setting Unit

This block carries out the instruction that sets the active vector length. A request gives a destination register index, a source register index with the value read from it, and an immediate. The immediate is the number of register slots the compiler set aside. The unit picks a new vector length and stores it in its length register. It then hands the value back for write-back to the destination register.

The same unit also holds the maximum-vector-length control register. Control-register swap operations reach it in two forms: one takes a register operand and one takes a 5-bit immediate. A request is accepted whenever `req_valid_i` is high, because the unit is always ready. The response comes one cycle later as a single-cycle `rsp_valid_o` pulse, together with a trap flag, a write-back enable, the destination index and the write-back data.

Top module: `vl_unit`

## Requirements
- R1: `req_op_i` selects the operation. 0 sets the vector length, 1 swaps the control register with `req_src_val_i`, 2 swaps it with the zero-extended low 5 bits of `req_imm_i`, and 3 is reserved and traps.
- R2: A set-length request whose immediate exceeds XLEN (unsigned) raises `rsp_trap_o`. The same applies to op 3.
- R3: A trapping request changes neither `vl_o` nor `mvl_o`, and gives `rsp_wb_en_o` = 0.
- R4: When the source index is 0, the new length equals the immediate.
- R5: When the source value is strictly greater than twice the immediate, the new length is XLEN. Twice the immediate is formed without overflow and compared unsigned.
- R6: When the source value is greater than the immediate but at most twice it, the new length is the source value shifted right by one.
- R7: In every other non-zero-source case, the new length equals the source value.
- R8: A set-length response carries the new length, zero-extended, on `rsp_wdata_o`, and the same value shows on `vl_o` from that cycle on.
- R9: A swap returns the previous control-register value on `rsp_wdata_o` and stores the new value.
- R10: `rsp_wb_en_o` is 0 whenever the destination index is 0.
- R11: After reset `vl_o` is 1, `mvl_o` is XLEN and `rsp_valid_o` is 0. Each accepted request produces exactly one `rsp_valid_o` pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Unit can take a request (always high) |
| req_op_i | input | 2 | Operation select |
| req_dst_i | input | 5 | Destination register index |
| req_src_idx_i | input | 5 | Source register index |
| req_src_val_i | input | XLEN | Source register value |
| req_imm_i | input | IMM_W | Immediate |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_trap_o | output | 1 | Illegal-instruction trap |
| rsp_wb_en_o | output | 1 | Destination write enable |
| rsp_dst_o | output | 5 | Destination index echoed |
| rsp_wdata_o | output | XLEN | Write-back data |
| vl_o | output | VL_W | Current vector length |
| mvl_o | output | XLEN | Current maximum-length register |

## Verification
Source values are chosen just below, at and just above both the immediate and twice the immediate. This shows exactly where each tier of the length rule begins. An odd value in the halving tier confirms that it rounds down, and a zero immediate with a non-zero source confirms the unsigned doubling and the XLEN clamp. Immediates equal to XLEN and one greater separate a legal request from a trap. A register-zero source with a large source value shows that the value is ignored in that case. Swaps with wide immediate bits confirm zero-extension, and back-to-back swaps confirm that the old value is returned.

// File: rtl/vl_pkg.sv
package vl_pkg;
  typedef enum logic [1:0] {
    OP_SETLEN = 2'd0,
    OP_SWAP_R = 2'd1,
    OP_SWAP_I = 2'd2,
    OP_RSVD   = 2'd3
  } vl_op_e;
endpackage

// File: rtl/vl_rule.sv
module vl_rule #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 12,
  parameter int VL_W  = $clog2(XLEN + 1)
) (
  input  logic              src_is_zero_i,
  input  logic [XLEN-1:0]   src_val_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic              trap_o,
  output logic [VL_W-1:0]   vl_o
);
  localparam int DBL_W = IMM_W + 1;
  localparam int CMP_W = (XLEN > DBL_W) ? XLEN + 1 : DBL_W + 1;

  logic [CMP_W-1:0] src_w, imm_w, dbl_w, xlen_w;

  assign src_w  = CMP_W'(src_val_i);
  assign imm_w  = CMP_W'(imm_i);
  assign dbl_w  = CMP_W'({imm_i, 1'b0});
  assign xlen_w = CMP_W'(XLEN);

  assign trap_o = imm_w > xlen_w;

  always_comb begin
    if (src_is_zero_i)        vl_o = VL_W'(imm_w);
    else if (src_w > dbl_w)   vl_o = VL_W'(XLEN);
    else if (src_w > imm_w)   vl_o = VL_W'(src_w >> 1);
    else                      vl_o = VL_W'(src_w);
  end

  // R5
  always_comb begin
    if (!trap_o && !src_is_zero_i && (src_w > dbl_w))
      clamp_chk: assert (vl_o == VL_W'(XLEN));
  end
endmodule

// File: rtl/vl_mvl_reg.sv
module vl_mvl_reg #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] rdata_o
);
  logic [XLEN-1:0] mvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mvl_q <= XLEN'(XLEN);
    else if (we_i) mvl_q <= wdata_i;
  end

  assign rdata_o = mvl_q;

  // R3
  mvl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mvl_q));
endmodule

// File: rtl/vl_unit.sv
module vl_unit
  import vl_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 12,
  parameter int IDX_W  = 5,
  parameter int UIMM_W = 5,
  parameter int VL_W   = $clog2(XLEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [IDX_W-1:0]  req_dst_i,
  input  logic [IDX_W-1:0]  req_src_idx_i,
  input  logic [XLEN-1:0]   req_src_val_i,
  input  logic [IMM_W-1:0]  req_imm_i,
  output logic              rsp_valid_o,
  output logic              rsp_trap_o,
  output logic              rsp_wb_en_o,
  output logic [IDX_W-1:0]  rsp_dst_o,
  output logic [XLEN-1:0]   rsp_wdata_o,
  output logic [VL_W-1:0]   vl_o,
  output logic [XLEN-1:0]   mvl_o
);
  vl_op_e           op;
  logic             acc;
  logic             rule_trap, trap;
  logic [VL_W-1:0]  rule_vl;
  logic             mvl_we;
  logic [XLEN-1:0]  mvl_wdata, mvl_rdata;
  logic [XLEN-1:0]  wdata_d;

  logic             rsp_valid_q, rsp_trap_q, rsp_wb_en_q;
  logic [IDX_W-1:0] rsp_dst_q;
  logic [XLEN-1:0]  rsp_wdata_q;
  logic [VL_W-1:0]  vl_q;

  assign req_ready_o = 1'b1;
  assign op  = vl_op_e'(req_op_i);
  assign acc = req_valid_i && req_ready_o;

  vl_rule #(.XLEN(XLEN), .IMM_W(IMM_W), .VL_W(VL_W)) u_rule (
    .src_is_zero_i (req_src_idx_i == '0),
    .src_val_i     (req_src_val_i),
    .imm_i         (req_imm_i),
    .trap_o        (rule_trap),
    .vl_o          (rule_vl)
  );

  always_comb begin
    trap      = 1'b0;
    mvl_we    = 1'b0;
    mvl_wdata = req_src_val_i;
    wdata_d   = mvl_rdata;
    unique case (op)
      OP_SETLEN: begin
        trap    = rule_trap;
        wdata_d = XLEN'(rule_vl);
      end
      OP_SWAP_R: mvl_we = acc;
      OP_SWAP_I: begin
        mvl_we    = acc;
        mvl_wdata = XLEN'(req_imm_i[UIMM_W-1:0]);
      end
      default: trap = 1'b1;
    endcase
  end

  vl_mvl_reg #(.XLEN(XLEN)) u_mvl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mvl_we),
    .wdata_i (mvl_wdata),
    .rdata_o (mvl_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_q        <= VL_W'(1);
      rsp_valid_q <= 1'b0;
      rsp_trap_q  <= 1'b0;
      rsp_wb_en_q <= 1'b0;
      rsp_dst_q   <= '0;
      rsp_wdata_q <= '0;
    end else begin
      rsp_valid_q <= acc;
      if (acc) begin
        rsp_trap_q  <= trap;
        rsp_wb_en_q <= !trap && (req_dst_i != '0);
        rsp_dst_q   <= req_dst_i;
        rsp_wdata_q <= trap ? '0 : wdata_d;
        if (op == OP_SETLEN && !trap) vl_q <= rule_vl;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_trap_o  = rsp_valid_q && rsp_trap_q;
  assign rsp_wb_en_o = rsp_valid_q && rsp_wb_en_q;
  assign rsp_dst_o   = rsp_dst_q;
  assign rsp_wdata_o = rsp_wdata_q;
  assign vl_o        = vl_q;
  assign mvl_o       = mvl_rdata;

  // R3
  trap_keeps_vl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_trap_o |-> $stable(vl_o) && !rsp_wb_en_o);
  // R10
  dst_zero_no_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_wb_en_o |-> rsp_dst_o != '0);
  // R11
  one_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> rsp_valid_o);
  // R11
  no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !rsp_valid_o);
  // R5
  vl_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vl_o <= VL_W'(XLEN));
  // R8
  vl_echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_wb_en_o && $changed(vl_o)) |-> rsp_wdata_o == XLEN'(vl_o));
endmodule

// File: tb/vl_unit_bench.sv
module vl_unit_bench;
  localparam int XLEN = 32;
  localparam int IMM_W = 12;
  localparam int VL_W = $clog2(XLEN + 1);
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [1:0] req_op = 0;
  logic [4:0] req_dst = 0, req_src_idx = 0;
  logic [XLEN-1:0] req_src_val = 0;
  logic [IMM_W-1:0] req_imm = 0;
  logic rsp_valid, rsp_trap, rsp_wb_en;
  logic [4:0] rsp_dst;
  logic [XLEN-1:0] rsp_wdata, mvl;
  logic [VL_W-1:0] vl;

  int n_chk = 0, n_bad = 0;
  int exp_vl = 1;
  logic [XLEN-1:0] exp_mvl = XLEN;

  always #(CLK_PERIOD/2) clk = ~clk;

  vl_unit u_vl_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_dst_i(req_dst), .req_src_idx_i(req_src_idx),
    .req_src_val_i(req_src_val), .req_imm_i(req_imm), .rsp_valid_o(rsp_valid),
    .rsp_trap_o(rsp_trap), .rsp_wb_en_o(rsp_wb_en), .rsp_dst_o(rsp_dst),
    .rsp_wdata_o(rsp_wdata), .vl_o(vl), .mvl_o(mvl)
  );

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] op, int dst, int sidx, longint sval, int imm);
    @(negedge clk);
    req_valid = 1; req_op = op; req_dst = 5'(dst); req_src_idx = 5'(sidx);
    req_src_val = XLEN'(sval); req_imm = IMM_W'(imm);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic t_reset;
    chk("R11 rsp_valid at reset", rsp_valid, 0);
    chk("R11 vl at reset", vl, 1);
    chk("R11 mvl at reset", mvl, XLEN);
  endtask

  // setlen with expectation computed from the tiered rule
  task automatic t_setlen(string req, int dst, int sidx, longint sval, int imm);
    longint e;
    if (sidx == 0) e = imm;
    else if (sval > 2 * imm) e = XLEN;
    else if (sval > imm) e = sval / 2;
    else e = sval;
    issue(2'd0, dst, sidx, sval, imm);
    exp_vl = int'(e);
    chk({req, " rsp_valid"}, rsp_valid, 1);
    chk({req, " trap"}, rsp_trap, 0);
    chk({req, " wdata"}, rsp_wdata, e);
    chk({req, " R8 vl"}, vl, e);
    chk({req, " R10 wb_en"}, rsp_wb_en, dst != 0);
    @(negedge clk);
    chk({req, " R11 single pulse"}, rsp_valid, 0);
  endtask

  task automatic t_trap(string req, logic [1:0] op, int imm);
    issue(op, 4, 3, 7, imm);
    chk({req, " trap"}, rsp_trap, 1);
    chk("R3 wb_en on trap", rsp_wb_en, 0);
    chk("R3 vl kept", vl, exp_vl);
    chk("R3 mvl kept", mvl, exp_mvl);
  endtask

  task automatic t_swap(string req, logic [1:0] op, int dst, longint sval, int imm);
    logic [XLEN-1:0] old = exp_mvl;
    issue(op, dst, 1, sval, imm);
    exp_mvl = (op == 2'd1) ? XLEN'(sval) : XLEN'(imm & 31);
    chk({req, " R9 old value"}, rsp_wdata, old);
    chk({req, " R9 new value"}, mvl, exp_mvl);
    chk({req, " R10 wb_en"}, rsp_wb_en, dst != 0);
    chk({req, " vl untouched"}, vl, exp_vl);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    t_reset();
    @(negedge clk); rst_n = 1;
    t_setlen("R4 src zero", 5, 0, 1000, 9);
    t_setlen("R4 src zero ignores value", 5, 0, 0, 32);
    t_setlen("R5 above double", 6, 2, 21, 10);
    t_setlen("R5 zero imm", 6, 2, 1, 0);
    t_setlen("R5 huge source", 6, 2, 64'hFFFF_FFFF, 32);
    t_setlen("R6 equal double", 7, 3, 20, 10);
    t_setlen("R6 odd rounds down", 7, 3, 15, 10);
    t_setlen("R6 just above imm", 7, 3, 11, 10);
    t_setlen("R7 equal imm", 8, 4, 10, 10);
    t_setlen("R7 below imm", 8, 4, 3, 10);
    t_setlen("R10 dst zero", 0, 4, 5, 10);
    t_setlen("R2 imm at XLEN legal", 9, 0, 0, XLEN);
    t_trap("R2 imm above XLEN", 2'd0, XLEN + 1);
    t_trap("R2 imm max", 2'd0, 4095);
    t_trap("R1 reserved op", 2'd3, 5);
    t_swap("R1 swap reg", 2'd1, 3, 64'hDEAD_BEEF, 0);
    t_swap("R1 swap imm zero-ext", 2'd2, 3, 0, 12'hFF3);
    t_swap("R9 swap back", 2'd1, 0, 17, 0);
    t_trap("R3 trap after swap", 2'd0, 100);
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule